// File: doc/BRIEF.md
# Link Integrity Check Scheduler

This block counts video frames while a content-protection link is authenticated. From that count it produces single-cycle strobes that tell the protection engine when to compute its short pattern value (Pj) and its slower verification value (Ri). It also produces strobes that tell the engine when to compare the local Ri against the value read back from the far end. The cipher arithmetic, the serial transport that fetches the remote value, and the authentication timers all sit outside the block. The remote value arrives on a port with a valid flag, and the local value is supplied alongside it.

Ri is compared twice around each Ri boundary: once on the frame just before the boundary and once on the boundary frame itself. This keeps both ends in step, and the earlier compare can be switched off. A test-mode input shortens both intervals by a factor of eight so that the checks can be exercised quickly. A failed or missing remote value at either compare sets a sticky mismatch flag.

Top module: `link_check_sched`

## Requirements
- R1: With the active mode normal (`test_mode_i` = 0), `pj_calc_o` pulses on every frame whose number in the current Ri period is a multiple of 16. Frames are numbered from 1 after enable or after a wrap.
- R2: With the active mode normal, `ri_calc_o` pulses on frame 128, and the frame numbering then wraps so that the next frame is frame 1.
- R3: With the active mode test (`test_mode_i` = 1), Pj pulses on every 2nd frame and Ri on every 16th frame.
- R4: `ri_cmp_bnd_o` pulses on each Ri boundary frame. `ri_cmp_pre_o` pulses on the frame before it (frame 127 of 128, or frame 15 of 16).
- R5: While `dis_sync_i` = 1 at the frame pulse, `ri_cmp_pre_o` stays low. `ri_cmp_bnd_o` and all other strobes are unaffected.
- R6: While `en_i` = 0 the frame count is held at zero and no strobe fires. The first frame pulse after `en_i` rises is frame 1. After reset every output is 0.
- R7: A change of `test_mode_i` while enabled takes effect only after the next Ri wrap. While disabled, the mode follows `test_mode_i` directly.
- R8: `mismatch_o` rises the cycle after a compare strobe if, in the strobe cycle, `remote_vld_i` = 0 or `local_ri_i` != `remote_ri_i`. It then stays high until `en_i` = 0. Differing values outside a compare cycle have no effect.
- R9: Every strobe is one cycle wide and appears in the cycle right after the clock edge that samples `frame_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Link authenticated; enables counting |
| frame_i | input | 1 | One-cycle frame-start pulse |
| test_mode_i | input | 1 | Shortened intervals (Pj 2, Ri 16) |
| dis_sync_i | input | 1 | Suppress the pre-boundary Ri compare |
| local_ri_i | input | RI_W | Locally computed Ri |
| remote_ri_i | input | RI_W | Ri read from the far end |
| remote_vld_i | input | 1 | Remote Ri is valid |
| pj_calc_o | output | 1 | Compute Pj strobe |
| ri_calc_o | output | 1 | Compute Ri strobe |
| ri_cmp_pre_o | output | 1 | Pre-boundary Ri compare strobe |
| ri_cmp_bnd_o | output | 1 | Boundary Ri compare strobe |
| mismatch_o | output | 1 | Sticky compare failure |

## Verification
Several properties are checked on every cycle: every strobe follows an accepted frame pulse, every Ri strobe coincides with a Pj strobe, the pre-compare is absent under the disable bit, strobes are quiet while disabled, the count stays below the active period, the mode changes only at a wrap, and the mismatch flag is sticky. Only the bench's frame sweeps can show that strobes land on the right frame numbers in each mode. The same holds for the deferred switch between modes, for the renumbering after a mid-period disable, and for the exact conditions under which the mismatch flag sets or stays clear.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef struct packed {
    logic pj;
    logic ri;
    logic pre;
    logic bnd;
  } lcs_strb_t;
endpackage

// File: rtl/lcs_frame_ctr.sv
module lcs_frame_ctr #(
  parameter int RI_LOG     = 7,
  parameter int TEST_SHIFT = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            frame_i,
  input  logic            test_i,
  output logic            adv_o,
  output logic            wrap_o,
  output logic            act_o,
  output logic [RI_LOG:0] next_o,
  output logic [RI_LOG:0] ri_len_o
);
  localparam int CW = RI_LOG + 1;
  localparam logic [CW-1:0] RI_N = CW'(1) << RI_LOG;
  localparam logic [CW-1:0] RI_T = CW'(1) << (RI_LOG - TEST_SHIFT);

  logic [RI_LOG-1:0] cnt_q;
  logic              act_q;

  assign ri_len_o = act_q ? RI_T : RI_N;
  assign next_o   = CW'(cnt_q) + CW'(1);
  assign wrap_o   = (next_o == ri_len_o);
  assign adv_o    = en_i & frame_i;
  assign act_o    = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      act_q <= test_i;
    end else if (frame_i) begin
      if (wrap_o) begin
        cnt_q <= '0;
        act_q <= test_i;  // mode switch only on period wrap
      end else begin
        cnt_q <= next_o[RI_LOG-1:0];
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(cnt_q) < ri_len_o); // R2
  AST_CNT_HELD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0); // R6
  AST_MODE_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != '0) |=> ($stable(act_q) || cnt_q == '0)); // R7
endmodule

// File: rtl/lcs_strobe_dec.sv
module lcs_strobe_dec
  import lcs_pkg::*;
#(
  parameter int PJ_LOG     = 4,
  parameter int RI_LOG     = 7,
  parameter int TEST_SHIFT = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            wrap_i,
  input  logic            act_i,
  input  logic            dis_sync_i,
  input  logic [RI_LOG:0] next_i,
  input  logic [RI_LOG:0] ri_len_i,
  output lcs_strb_t       strb_o
);
  localparam int CW = RI_LOG + 1;
  localparam logic [CW-1:0] PJ_N = CW'(1) << PJ_LOG;
  localparam logic [CW-1:0] PJ_T = CW'(1) << (PJ_LOG - TEST_SHIFT);

  logic [CW-1:0] pj_mask;
  logic          pj_hit, pre_hit;

  assign pj_mask = act_i ? (PJ_T - CW'(1)) : (PJ_N - CW'(1));
  assign pj_hit  = (next_i & pj_mask) == '0;
  assign pre_hit = (next_i == ri_len_i - CW'(1)) && !dis_sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_o <= '0;
    end else begin
      strb_o <= '0;
      if (adv_i) begin
        strb_o.pj  <= pj_hit;
        strb_o.ri  <= wrap_i;
        strb_o.bnd <= wrap_i;
        strb_o.pre <= pre_hit;
      end
    end
  end

  AST_STROBE_AFTER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|strb_o) |-> $past(adv_i)); // R9
  AST_PJ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_o.pj |=> !strb_o.pj); // R9
  AST_RI_ON_PJ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_o.ri |-> strb_o.pj); // R2
  AST_PRE_SUPPRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_o.pre |-> !$past(dis_sync_i)); // R5
endmodule

// File: rtl/lcs_mismatch.sv
module lcs_mismatch #(
  parameter int RI_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            cmp_i,
  input  logic            vld_i,
  input  logic [RI_W-1:0] local_i,
  input  logic [RI_W-1:0] remote_i,
  output logic            flag_o
);
  logic bad;
  assign bad = !vld_i || (local_i != remote_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            flag_o <= 1'b0;
    else if (!en_i)         flag_o <= 1'b0;
    else if (cmp_i && bad)  flag_o <= 1'b1;
  end

  AST_MISMATCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && flag_o) |=> flag_o); // R8
  AST_MISMATCH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !flag_o); // R8
endmodule

// File: rtl/link_check_sched.sv
module link_check_sched
  import lcs_pkg::*;
#(
  parameter int PJ_LOG     = 4,
  parameter int RI_LOG     = 7,
  parameter int TEST_SHIFT = 3,
  parameter int RI_W       = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            frame_i,
  input  logic            test_mode_i,
  input  logic            dis_sync_i,
  input  logic [RI_W-1:0] local_ri_i,
  input  logic [RI_W-1:0] remote_ri_i,
  input  logic            remote_vld_i,
  output logic            pj_calc_o,
  output logic            ri_calc_o,
  output logic            ri_cmp_pre_o,
  output logic            ri_cmp_bnd_o,
  output logic            mismatch_o
);
  logic            adv, wrap, act;
  logic [RI_LOG:0] next_cnt, ri_len;
  lcs_strb_t       strb;

  lcs_frame_ctr #(.RI_LOG(RI_LOG), .TEST_SHIFT(TEST_SHIFT)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .frame_i  (frame_i),
    .test_i   (test_mode_i),
    .adv_o    (adv),
    .wrap_o   (wrap),
    .act_o    (act),
    .next_o   (next_cnt),
    .ri_len_o (ri_len)
  );

  lcs_strobe_dec #(.PJ_LOG(PJ_LOG), .RI_LOG(RI_LOG), .TEST_SHIFT(TEST_SHIFT)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .wrap_i     (wrap),
    .act_i      (act),
    .dis_sync_i (dis_sync_i),
    .next_i     (next_cnt),
    .ri_len_i   (ri_len),
    .strb_o     (strb)
  );

  lcs_mismatch #(.RI_W(RI_W)) u_mm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .cmp_i    (strb.pre | strb.bnd),
    .vld_i    (remote_vld_i),
    .local_i  (local_ri_i),
    .remote_i (remote_ri_i),
    .flag_o   (mismatch_o)
  );

  assign pj_calc_o    = strb.pj;
  assign ri_calc_o    = strb.ri;
  assign ri_cmp_pre_o = strb.pre;
  assign ri_cmp_bnd_o = strb.bnd;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(pj_calc_o || ri_calc_o || ri_cmp_pre_o || ri_cmp_bnd_o)); // R6
endmodule

// File: tb/tb_link_check_sched.sv
module tb_link_check_sched;
  localparam int RI_W = 16;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            en_i = 1'b0, frame_i = 1'b0, test_mode_i = 1'b0, dis_sync_i = 1'b0;
  logic [RI_W-1:0] local_ri_i = '0, remote_ri_i = '0;
  logic            remote_vld_i = 1'b1;
  logic            pj_calc_o, ri_calc_o, ri_cmp_pre_o, ri_cmp_bnd_o, mismatch_o;

  int checks = 0, errors = 0;
  int mcnt = 0;
  bit mact = 0, mm = 0;
  string cur = "R1";

  always #2.5 clk = ~clk;

  link_check_sched #(.RI_W(RI_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .frame_i(frame_i),
    .test_mode_i(test_mode_i), .dis_sync_i(dis_sync_i),
    .local_ri_i(local_ri_i), .remote_ri_i(remote_ri_i), .remote_vld_i(remote_vld_i),
    .pj_calc_o(pj_calc_o), .ri_calc_o(ri_calc_o), .ri_cmp_pre_o(ri_cmp_pre_o),
    .ri_cmp_bnd_o(ri_cmp_bnd_o), .mismatch_o(mismatch_o)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b (frame model %0d)", req, what, act, exp, mcnt);
    end
  endtask

  task automatic set_en(bit v);
    @(negedge clk);
    en_i = v;
    if (!v) begin mcnt = 0; mm = 0; end
    else mact = test_mode_i;
  endtask

  task automatic do_frame();
    bit e_pj, e_ri, e_pre, e_bnd;
    int n, rip, pjp;
    @(negedge clk);
    frame_i = 1'b1;
    e_pj = 0; e_ri = 0; e_pre = 0; e_bnd = 0;
    if (en_i) begin
      n   = mcnt + 1;
      rip = mact ? 16 : 128;
      pjp = mact ? 2 : 16;
      e_pj  = (n % pjp) == 0;
      e_ri  = (n == rip);
      e_bnd = e_ri;
      e_pre = (n == rip - 1) && !dis_sync_i;
      if (e_ri) begin mcnt = 0; mact = test_mode_i; end
      else mcnt = n;
    end
    @(negedge clk);
    frame_i = 1'b0;
    chk(cur, "pj_calc", pj_calc_o, e_pj);
    chk(cur, "ri_calc", ri_calc_o, e_ri);
    chk(cur, "ri_cmp_pre", ri_cmp_pre_o, e_pre);
    chk(cur, "ri_cmp_bnd", ri_cmp_bnd_o, e_bnd);
    if ((e_pre || e_bnd) && (!remote_vld_i || local_ri_i != remote_ri_i)) mm = 1;
    @(negedge clk);
    chk("R9", "strobes one cycle", pj_calc_o | ri_calc_o | ri_cmp_pre_o | ri_cmp_bnd_o, 1'b0);
    chk("R8", "mismatch", mismatch_o, mm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6", "reset pj", pj_calc_o, 1'b0);
    chk("R6", "reset ri", ri_calc_o, 1'b0);
    chk("R6", "reset pre", ri_cmp_pre_o, 1'b0);
    chk("R6", "reset bnd", ri_cmp_bnd_o, 1'b0);
    chk("R6", "reset mismatch", mismatch_o, 1'b0);
    rst_ni = 1'b1;

    // R6: frames ignored while disabled
    cur = "R6";
    for (int i = 0; i < 5; i++) do_frame();

    // R1 R2 R4: normal mode sweep over two periods and more
    cur = "R1";
    set_en(1);
    for (int i = 0; i < 300; i++) do_frame();

    // R5: pre-compare suppressed across a boundary
    cur = "R5";
    dis_sync_i = 1'b1;
    for (int i = 0; i < 140; i++) do_frame();
    dis_sync_i = 1'b0;

    // R7: mode request mid-period waits for the wrap
    cur = "R7";
    for (int i = 0; i < 20; i++) do_frame();
    test_mode_i = 1'b1;
    for (int i = 0; i < 150; i++) do_frame();

    // R3 R4: test mode sweep
    cur = "R3";
    for (int i = 0; i < 60; i++) do_frame();

    // R6: disable mid-period, renumber from frame 1
    cur = "R6";
    for (int i = 0; i < 7; i++) do_frame();
    set_en(0);
    for (int i = 0; i < 3; i++) do_frame();
    set_en(1);
    for (int i = 0; i < 40; i++) do_frame();

    // R8: mismatch outside compare ignored, then at compare sticky
    cur = "R8";
    set_en(0);
    set_en(1);
    local_ri_i = 16'h1234;
    remote_ri_i = 16'h1234;
    for (int i = 0; i < 5; i++) do_frame();
    remote_ri_i = 16'h4321;
    do_frame();              // frame 6: no compare
    chk("R8", "differ outside compare", mismatch_o, 1'b0);
    remote_ri_i = 16'h1234;
    for (int i = 0; i < 8; i++) do_frame();   // frames 7..14
    remote_ri_i = 16'h0001;
    do_frame();              // frame 15: pre compare
    chk("R8", "set at pre compare", mismatch_o, 1'b1);
    remote_ri_i = 16'h1234;
    for (int i = 0; i < 20; i++) do_frame();
    chk("R8", "sticky", mismatch_o, 1'b1);
    set_en(0);
    @(negedge clk);
    chk("R8", "cleared by disable", mismatch_o, 1'b0);
    set_en(1);
    dis_sync_i = 1'b1;
    for (int i = 0; i < 15; i++) do_frame();   // pre at 15 suppressed
    remote_vld_i = 1'b0;
    do_frame();              // frame 16 after 15? model decides boundary
    remote_vld_i = 1'b1;
    do_frame();
    dis_sync_i = 1'b0;
    for (int i = 0; i < 20; i++) do_frame();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule